// File: doc/BRIEF.md
# Block Protection and Write-Enable Controller

This block keeps the protection configuration and the operation status bits of a serial NAND-style memory, and rules on every program or erase request whether the addressed 18-bit row may be modified. A host writes the protection byte through a feature-write port (register address plus data byte) and reads either byte back through a combinational feature-read port. A protection switch bit, together with the external write-protect pin, can freeze the range bits so that software can no longer widen access.

Three range bits choose a power-of-two fraction of the row space, from 1/64 to 1/2. An orientation bit places that fraction at the top or the bottom of the array, and a complement bit locks everything outside it instead. A request passes only when the write-enable latch is set, no accepted operation is still in progress, and the row lies outside the locked range. A locked request raises a fail flag without ever raising the busy flag. The array side reports completion through a done strobe.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset the protection byte reads back with range code 111 and the orientation, complement and switch bits all 0. WEL, busy, program-fail and erase-fail are all 0.
- R2: The protection byte sits at feature address A0h with switch bit 7, range code bits 5:3, orientation bit 2 and complement bit 1. Bits 6 and 0 are reserved: they are discarded on write and read back as 0.
- R3: When the switch bit is 1 and wp_n is low, a write to A0h leaves the range code, orientation and complement bits unchanged. The switch bit itself is still updated.
- R4: Range code 000 locks no row and code 111 locks every row, whatever the orientation and complement bits hold. With orientation 0 and complement 0, codes 001 to 110 lock the top 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of rows (code 001 locks 3F000h to 3FFFFh).
- R5: With orientation 1 and complement 0, codes 001 to 110 lock the same fractions at the bottom of the row space (code 001 locks 00000h to 00FFFh).
- R6: With complement 1, codes 001 to 110 lock every row outside the region that the orientation bit selects (orientation 0, code 001 locks 00000h to 3EFFFh).
- R7: A write-enable strobe sets WEL and a write-disable strobe clears it.
- R8: A program or erase request made while WEL is 0, or while busy is 1, is ignored. It produces no grant and changes no status bit.
- R9: An enabled request to a locked row gives no grant. It sets program-fail (op_erase=0) or erase-fail (op_erase=1) one cycle later, clears WEL, and leaves busy at 0.
- R10: An enabled request to an unlocked row asserts op_grant in the same cycle. In the next cycle it sets busy and clears both fail flags. op_done while busy clears busy and WEL.
- R11: The device-reset strobe always clears busy and WEL. It clears both fail flags only when busy was 0.
- R12: The status byte at feature address C0h reads {4'b0, program-fail, erase-fail, WEL, busy} (bits 5:4 are an always-zero ECC field). Writes to C0h have no effect, and every other address reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_wr_en | input | 1 | Feature write strobe |
| feat_addr | input | 8 | Feature write address |
| feat_wdata | input | 8 | Feature write data |
| feat_rd_addr | input | 8 | Feature read address |
| feat_rdata | output | 8 | Feature read data (combinational) |
| wp_n | input | 1 | Write-protect pin level, active low |
| wel_set_cmd | input | 1 | Write-enable strobe |
| wel_clr_cmd | input | 1 | Write-disable strobe |
| dev_reset_cmd | input | 1 | Device-reset strobe |
| op_valid | input | 1 | Program/erase request strobe |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_row | input | ROW_W | Row address of the request |
| op_done | input | 1 | Array reports the accepted operation finished |
| op_grant | output | 1 | Request accepted this cycle |
| op_locked | output | 1 | op_row falls in the locked range |
| wel | output | 1 | Write-enable latch |
| oip | output | 1 | Operation in progress |
| prog_fail | output | 1 | Program rejected on a locked row |
| erase_fail | output | 1 | Erase rejected on a locked row |

## Verification
A wrong range code, orientation or complement bit shows up on op_locked in the same cycle, for the rows that sit on either side of each fraction boundary. It also shows on the protection byte as soon as that byte is read. A wrong WEL or busy bit shows one cycle after the strobe that should have moved it, both on the dedicated outputs and in the status byte. It also shows as a grant that appears or goes missing on the next request. A fail flag that is set or cleared in error shows on the cycle after the request or reset strobe. The reference model is compared on every clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/blk_lock_pkg.sv
// Shared types and constants for the block protection controller.
// Assumes an 8-bit feature data path and a 3-bit range code.
package blk_lock_pkg;
    localparam int BP_W = 3;

    // Stored protection configuration; reserved bits are not kept.
    typedef struct packed {
        logic            brwd;
        logic [BP_W-1:0] bp;
        logic            inv;
        logic            cmp;
    } lock_cfg_t;

    localparam lock_cfg_t LOCK_CFG_RST = '{brwd: 1'b0, bp: '1, inv: 1'b0, cmp: 1'b0};

    // Assemble the readable protection byte; reserved positions read 0.
    function automatic logic [7:0] lock_to_byte(lock_cfg_t c);
        return {c.brwd, 1'b0, c.bp, c.inv, c.cmp, 1'b0};
    endfunction
endpackage

// File: rtl/blk_lock_row_match.sv
// Combinational locked-range decision for one row address.
// The code space of BP_W bits gives (2**BP_W - 2) fractional regions: code k
// covers 1 / 2**(2**BP_W - 1 - k) of the rows, matched on the top row bits.
// Assumes ROW_W >= 2**BP_W - 2 so every slice is in range.
module blk_lock_row_match #(
    parameter int ROW_W = 18,
    parameter int BP_W  = 3
) (
    input  logic [ROW_W-1:0] row,
    input  logic [BP_W-1:0]  bp,
    input  logic             inv,
    input  logic             cmp,
    output logic             locked
);
    localparam int NCODE = (1 << BP_W) - 1;
    localparam logic [BP_W-1:0] CODE_ALL  = '1;
    localparam logic [BP_W-1:0] CODE_NONE = '0;

    logic [NCODE:0] in_region;

    assign in_region[0]     = 1'b0;
    assign in_region[NCODE] = 1'b1;

    // One slice compare per fractional code: all-ones for top, all-zeros for bottom.
    for (genvar k = 1; k < NCODE; k++) begin : g_code
        localparam int NB = NCODE - k;
        logic top_hit;
        logic bot_hit;
        assign top_hit      = &row[ROW_W-1 -: NB];
        assign bot_hit      = ~|row[ROW_W-1 -: NB];
        assign in_region[k] = inv ? bot_hit : top_hit;
    end

    // Final decision: none and all codes ignore orientation and complement.
    always_comb begin
        if (bp == CODE_NONE)     locked = 1'b0;
        else if (bp == CODE_ALL) locked = 1'b1;
        else                     locked = in_region[bp] ^ cmp;
    end
endmodule

// File: rtl/blk_lock_cfg_reg.sv
// Protection configuration register with hardware freeze.
// Assumes the caller has already decoded the feature address; wr is the
// qualified write strobe. The freeze uses the switch bit held before the write.
module blk_lock_cfg_reg
    import blk_lock_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            wr_brwd,
    input  logic [BP_W-1:0] wr_bp,
    input  logic            wr_inv,
    input  logic            wr_cmp,
    input  logic            wp_n,
    output lock_cfg_t       cfg
);
    logic frozen;

    // Range bits are frozen when the switch is on and the pin is driven low.
    always_comb frozen = cfg.brwd & ~wp_n;

    // Register update: switch bit always writable, range bits only when not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= LOCK_CFG_RST;
        end else if (wr) begin
            cfg.brwd <= wr_brwd;
            if (!frozen) begin
                cfg.bp  <= wr_bp;
                cfg.inv <= wr_inv;
                cfg.cmp <= wr_cmp;
            end
        end
    end
endmodule

// File: rtl/blk_lock_status.sv
// Write-enable latch, busy flag and fail flags with request arbitration.
// Per-cycle priority: device reset, completion, grant/reject, enable strobes.
// Assumes op_done is only meaningful while busy.
module blk_lock_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic dev_reset,
    input  logic op_valid,
    input  logic op_erase,
    input  logic row_locked,
    input  logic op_done,
    output logic op_grant,
    output logic wel,
    output logic oip,
    output logic prog_fail,
    output logic erase_fail
);
    logic can_start;
    logic reject;

    // Request qualification against latch, busy flag and lock decision.
    always_comb begin
        can_start = op_valid & wel & ~oip;
        op_grant  = can_start & ~row_locked;
        reject    = can_start & row_locked;
    end

    // Status state update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel        <= 1'b0;
            oip        <= 1'b0;
            prog_fail  <= 1'b0;
            erase_fail <= 1'b0;
        end else if (dev_reset) begin
            wel <= 1'b0;
            oip <= 1'b0;
            if (!oip) begin
                prog_fail  <= 1'b0;
                erase_fail <= 1'b0;
            end
        end else if (op_done && oip) begin
            oip <= 1'b0;
            wel <= 1'b0;
        end else if (op_grant) begin
            oip        <= 1'b1;
            prog_fail  <= 1'b0;
            erase_fail <= 1'b0;
        end else if (reject) begin
            wel <= 1'b0;
            if (op_erase) erase_fail <= 1'b1;
            else          prog_fail  <= 1'b1;
        end else if (wel_set) begin
            wel <= 1'b1;
        end else if (wel_clr) begin
            wel <= 1'b0;
        end
    end
endmodule

// File: rtl/blk_lock_ctrl.sv
// Top of the block protection controller: feature decode, read mux,
// configuration register, row range decision and status sequencer.
// Assumes at most one command strobe per cycle from the host side.
module blk_lock_ctrl #(
    parameter int          ROW_W     = 18,
    parameter logic [7:0]  LOCK_ADDR = 8'hA0,
    parameter logic [7:0]  STAT_ADDR = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_wr_en,
    input  logic [7:0]       feat_addr,
    input  logic [7:0]       feat_wdata,
    input  logic [7:0]       feat_rd_addr,
    output logic [7:0]       feat_rdata,
    input  logic             wp_n,
    input  logic             wel_set_cmd,
    input  logic             wel_clr_cmd,
    input  logic             dev_reset_cmd,
    input  logic             op_valid,
    input  logic             op_erase,
    input  logic [ROW_W-1:0] op_row,
    input  logic             op_done,
    output logic             op_grant,
    output logic             op_locked,
    output logic             wel,
    output logic             oip,
    output logic             prog_fail,
    output logic             erase_fail
);
    import blk_lock_pkg::*;

    lock_cfg_t lock_cfg;
    logic      lock_wr;
    logic      unused_rsvd;

    // Address qualification of the protection byte write.
    always_comb lock_wr = feat_wr_en && (feat_addr == LOCK_ADDR);

    // Reserved data bits are dropped on purpose.
    assign unused_rsvd = feat_wdata[6] ^ feat_wdata[0];

    blk_lock_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (lock_wr),
        .wr_brwd (feat_wdata[7]),
        .wr_bp   (feat_wdata[5:3]),
        .wr_inv  (feat_wdata[2]),
        .wr_cmp  (feat_wdata[1]),
        .wp_n    (wp_n),
        .cfg     (lock_cfg)
    );

    blk_lock_row_match #(.ROW_W(ROW_W), .BP_W(BP_W)) i_match (
        .row    (op_row),
        .bp     (lock_cfg.bp),
        .inv    (lock_cfg.inv),
        .cmp    (lock_cfg.cmp),
        .locked (op_locked)
    );

    blk_lock_status i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wel_set    (wel_set_cmd),
        .wel_clr    (wel_clr_cmd),
        .dev_reset  (dev_reset_cmd),
        .op_valid   (op_valid),
        .op_erase   (op_erase),
        .row_locked (op_locked),
        .op_done    (op_done),
        .op_grant   (op_grant),
        .wel        (wel),
        .oip        (oip),
        .prog_fail  (prog_fail),
        .erase_fail (erase_fail)
    );

    // Feature read mux; unmapped addresses return zero.
    always_comb begin
        if (feat_rd_addr == LOCK_ADDR)      feat_rdata = lock_to_byte(lock_cfg);
        else if (feat_rd_addr == STAT_ADDR) feat_rdata = {4'b0000, prog_fail, erase_fail, wel, oip};
        else                                feat_rdata = 8'h00;
    end
endmodule

// File: rtl/blk_lock_ctrl_chk.sv
// Property checker for blk_lock_ctrl, attached by bind.
module blk_lock_ctrl_chk
    import blk_lock_pkg::*;
#(
    parameter logic [7:0] LOCK_ADDR = 8'hA0
) (
    input logic      clk,
    input logic      rst_n,
    input logic      feat_wr_en,
    input logic [7:0] feat_addr,
    input logic      wp_n,
    input logic      wel_set_cmd,
    input logic      dev_reset_cmd,
    input logic      op_valid,
    input logic      op_done,
    input logic      op_grant,
    input logic      op_locked,
    input logic      wel,
    input logic      oip,
    input logic      prog_fail,
    input logic      erase_fail,
    input lock_cfg_t cfg
);
    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg.bp == 3'b111) && !cfg.brwd && !wel && !oip && !prog_fail && !erase_fail);

    // R3: frozen range bits hold across a write
    a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_wr_en && feat_addr == LOCK_ADDR && cfg.brwd && !wp_n)
        |=> $stable(cfg.bp) && $stable(cfg.inv) && $stable(cfg.cmp));

    // R4: the all code locks every row
    a_r4_all_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.bp == 3'b111) |-> op_locked);

    // R4: the none code locks no row
    a_r4_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.bp == 3'b000) |-> !op_locked);

    // R7: write-enable strobe with nothing else pending sets the latch
    a_r7_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set_cmd && !dev_reset_cmd && !op_valid && !op_done) |=> wel);

    // R8: a request without the latch changes no fail flag and starts nothing
    a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wel && !oip && !dev_reset_cmd)
        |=> $stable(prog_fail) && $stable(erase_fail) && !oip);

    // R9: a locked enabled request never raises busy and drops the latch
    a_r9_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wel && !oip && op_locked && !dev_reset_cmd) |=> !oip && !wel);

    // R10: a grant raises busy on the next cycle
    a_r10_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_grant && !dev_reset_cmd) |=> oip);
endmodule

bind blk_lock_ctrl blk_lock_ctrl_chk #(.LOCK_ADDR(LOCK_ADDR)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .feat_wr_en    (feat_wr_en),
    .feat_addr     (feat_addr),
    .wp_n          (wp_n),
    .wel_set_cmd   (wel_set_cmd),
    .dev_reset_cmd (dev_reset_cmd),
    .op_valid      (op_valid),
    .op_done       (op_done),
    .op_grant      (op_grant),
    .op_locked     (op_locked),
    .wel           (wel),
    .oip           (oip),
    .prog_fail     (prog_fail),
    .erase_fail    (erase_fail),
    .cfg           (lock_cfg)
);

// File: tb/test_blk_lock_ctrl.sv
module test_blk_lock_ctrl;
    localparam logic [7:0] A_LOCK = 8'hA0;
    localparam logic [7:0] A_STAT = 8'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_wr_en = 0;
    logic [7:0] feat_addr = 0, feat_wdata = 0, feat_rd_addr = A_STAT;
    logic [7:0] feat_rdata;
    logic wp_n = 1, wel_set_cmd = 0, wel_clr_cmd = 0, dev_reset_cmd = 0;
    logic op_valid = 0, op_erase = 0, op_done = 0;
    logic [17:0] op_row = 0;
    logic op_grant, op_locked, wel, oip, prog_fail, erase_fail;

    blk_lock_ctrl i_blk_lock_ctrl (.*);

    always #2 clk = ~clk;

    int vectors = 0, errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Reference state
    bit m_brwd = 0, m_inv = 0, m_cmp = 0;
    int m_bp = 7;
    bit m_wel = 0, m_oip = 0, m_pf = 0, m_ef = 0;

    function automatic bit ref_lock(int row, int bp, bit inv, bit cmp);
        int sz;
        bit hit;
        if (bp == 0) return 0;
        if (bp == 7) return 1;
        sz = 1 << (11 + bp);
        hit = inv ? (row < sz) : (row >= (1 << 18) - sz);
        return hit ^ cmp;
    endfunction

    function automatic int ref_rd(logic [7:0] a);
        if (a == A_LOCK) return m_brwd * 128 + m_bp * 8 + m_inv * 4 + m_cmp * 2;
        if (a == A_STAT) return m_pf * 8 + m_ef * 4 + m_wel * 2 + m_oip;
        return 0;
    endfunction

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // One clock: compare mid-low-phase, advance model at the edge.
    task automatic cyc();
        bit lk, g, frz;
        #1;
        lk = ref_lock(op_row, m_bp, m_inv, m_cmp);
        g = op_valid && m_wel && !m_oip && !lk;
        chk("rdata", feat_rdata, ref_rd(feat_rd_addr));
        chk("wel", wel, m_wel);
        chk("oip", oip, m_oip);
        chk("prog_fail", prog_fail, m_pf);
        chk("erase_fail", erase_fail, m_ef);
        chk("op_locked", op_locked, lk);
        chk("op_grant", op_grant, g);
        @(posedge clk);
        if (feat_wr_en && feat_addr == A_LOCK) begin
            frz = m_brwd && !wp_n;
            if (!frz) begin
                m_bp = feat_wdata[5:3]; m_inv = feat_wdata[2]; m_cmp = feat_wdata[1];
            end
            m_brwd = feat_wdata[7];
        end
        if (dev_reset_cmd) begin
            if (!m_oip) begin m_pf = 0; m_ef = 0; end
            m_wel = 0; m_oip = 0;
        end else if (op_done && m_oip) begin
            m_oip = 0; m_wel = 0;
        end else if (g) begin
            m_oip = 1; m_pf = 0; m_ef = 0;
        end else if (op_valid && m_wel && !m_oip) begin
            m_wel = 0;
            if (op_erase) m_ef = 1; else m_pf = 1;
        end else if (wel_set_cmd) m_wel = 1;
        else if (wel_clr_cmd) m_wel = 0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        feat_wr_en = 1; feat_addr = a; feat_wdata = d; cyc(); feat_wr_en = 0;
    endtask
    task automatic we();  wel_set_cmd = 1; cyc(); wel_set_cmd = 0; endtask
    task automatic wd();  wel_clr_cmd = 1; cyc(); wel_clr_cmd = 0; endtask
    task automatic drst(); dev_reset_cmd = 1; cyc(); dev_reset_cmd = 0; endtask
    task automatic op(bit er, int row);
        op_valid = 1; op_erase = er; op_row = row; cyc(); op_valid = 0;
    endtask
    task automatic done(); op_done = 1; cyc(); op_done = 0; endtask
    task automatic probe(int row); op_row = row; cyc(); endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int rows[10] = '{0, 'h00FFF, 'h01000, 'h1FFFF, 'h20000, 'h2FFFF,
                         'h3EFFF, 'h3F000, 'h3FFFF, 'h12345};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, both bytes
        cur_req = "R1"; feat_rd_addr = A_STAT; cyc();
        feat_rd_addr = A_LOCK; cyc();
        // R12: status ignores writes, unmapped reads zero
        cur_req = "R12"; feat_rd_addr = A_STAT; wr(A_STAT, 8'hFF); cyc();
        feat_rd_addr = 8'h55; cyc();
        // R7: enable and disable strobes
        cur_req = "R7"; feat_rd_addr = A_STAT; we(); cyc(); wd(); cyc();
        // R2: reserved bits dropped
        cur_req = "R2"; feat_rd_addr = A_LOCK; wr(A_LOCK, 8'h41); cyc(); wr(A_LOCK, 8'hFF); cyc();
        // R4 R5 R6: all codes, orientations and complements
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 2; v++)
                for (int b = 0; b < 8; b++) begin
                    cur_req = (c == 1) ? "R6" : (v == 1) ? "R5" : "R4";
                    wr(A_LOCK, 8'((b << 3) | (v << 2) | (c << 1)));
                    foreach (rows[i]) probe(rows[i]);
                end
        // R3: freeze by switch bit and pin
        cur_req = "R3";
        wr(A_LOCK, 8'h80 | 8'h08); wp_n = 0; cyc();
        wr(A_LOCK, 8'h80 | 8'h30 | 8'h06); cyc(); probe('h3F800);
        wr(A_LOCK, 8'h00); cyc();          // switch clears, range still frozen
        wr(A_LOCK, 8'h10); cyc();          // now writable with pin still low
        wp_n = 1;
        // R8: no latch, then busy
        cur_req = "R8"; feat_rd_addr = A_STAT; wr(A_LOCK, 8'h00);
        op(0, 'h100); cyc(); op(1, 'h100); cyc();
        we(); op(0, 'h200); op(1, 'h300); cyc();
        // R10: completion
        cur_req = "R10"; done(); cyc();
        // R9: locked program and erase
        cur_req = "R9"; wr(A_LOCK, 8'h38);
        we(); op(0, 'h3FFFF); cyc(); we(); op(1, 'h00000); cyc();
        // R10: grant clears fail flags
        cur_req = "R10"; wr(A_LOCK, 8'h08); we(); op(1, 'h00010); cyc(); done(); cyc();
        // R11: reset while idle and while busy
        cur_req = "R11"; we(); op(0, 'h3F001); cyc(); drst(); cyc();
        we(); op(0, 'h3F001); we(); drst(); cyc();
        we(); op(0, 'h00001); drst(); cyc(); done(); cyc();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule